// File: doc/BRIEF.md
# JTAG Debug Port Scan Registers

This block is the target side of a JTAG debug port. A standard sixteen-state TAP controller runs from the test clock and steers a 4-bit instruction register. The instruction picks which data register sits between the serial input and the serial output. The choices are a 1-bit bypass cell, a 32-bit identification value, two 35-bit access registers and an abort register. Every opcode that is not in the table falls back to the bypass cell, including the boundary-scan test opcodes, which are not implemented.

The two access registers are asymmetric. A scan shifts in write data, a 2-bit register address and a read flag. The same scan shifts out the data of the previous read and a 3-bit acknowledge. When the scan leaves Update-DR, a debug-port access reads or writes a small internal bank: a reserved slot, a control/status word, a select word and a read buffer. An access-port access instead issues a single-cycle request on a simple request/response port.

An access-port transaction that is still outstanding makes the next access scan report WAIT and drops that scan's request. Writing bit 0 of the abort register sends a one-cycle abort pulse to the access port.

Top module: `jdp_port`

## Requirements
- R1: The TAP controller follows the standard 16-state sequence on rising TCK edges. Five consecutive edges with TMS high reach Test-Logic-Reset from any state. A high `trst`, sampled on a rising edge, also forces Test-Logic-Reset.
- R2: The instruction register is 4 bits wide and shifts least significant bit first. Capture-IR loads 0001. Test-Logic-Reset loads the identification opcode 1110, and a new opcode takes effect on the edge that leaves Update-IR.
- R3: The opcodes select data registers as follows: 1111 the bypass cell (1 bit), 1110 identification (32 bits), 1010 debug-port access (35 bits), 1011 access-port access (35 bits), 1000 abort (32 bits). Every other opcode selects the bypass cell.
- R4: Capture-DR loads 0 into the bypass cell and loads 0x3BA00477 into the identification register. In that value, bits 31:28 are the version 3, bits 27:12 are the part number 0xBA00, bits 11:1 are the manufacturer code and bit 0 is 1.
- R5: An access scan shifts in, least significant bit first, a 35-bit word laid out as follows: bits 34:3 are write data, bits 2:1 are the register address and bit 0 is the read flag (1 = read, 0 = write).
- R6: An access-register capture loads the data of the previous read into bits 34:3 and the acknowledge into bits 2:0. The acknowledge is 010 (OK) when no access-port transaction is outstanding and 001 (WAIT) otherwise. No other acknowledge code is ever loaded.
- R7: The debug-port bank, by address: 00 is reserved, reads 0 and ignores writes; 01 is the control/status word and can be read and written; 10 is the select word and can be read and written; 11 is the read buffer, which returns the last access-port read result, ignores writes and starts no access-port transaction.
- R8: An accepted access-port scan raises `ap_req_valid` for exactly one cycle, one edge after Update-DR is left. The request carries `ap_req_write` (the inverse of the read flag), the address and the write data. The data of a read response becomes the read buffer and the data of the next access capture.
- R9: An access-port transaction is outstanding from its request until `ap_rsp_valid` or an abort. If an access scan of either kind captured while a transaction was outstanding, its Update-DR is dropped: no request is issued and no bank register changes.
- R10: An abort scan captures 0. Updating it with bit 0 set raises `ap_abort` for one cycle and ends any outstanding transaction. Updating it with bit 0 clear has no effect.
- R11: `tdo` and `tdo_en` change only on falling TCK edges. `tdo_en` is 1 only while the TAP is in Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while tdo is being driven (shift states) |
| ap_req_valid | output | 1 | One-cycle access-port request strobe |
| ap_req_write | output | 1 | Request is a write (1) or a read (0) |
| ap_req_addr | output | 2 | Access-port register address |
| ap_req_wdata | output | 32 | Access-port write data |
| ap_rsp_valid | input | 1 | Access-port response strobe |
| ap_rsp_rdata | input | 32 | Access-port read response data |
| ap_abort | output | 1 | One-cycle abort pulse to the access port |

## Verification
Serial output bits are valid from the falling edge that follows Capture-IR or Capture-DR. The bench therefore reads `tdo` shortly after each falling edge, and shortly after each rising edge it confirms that `tdo` did not move. Request and abort strobes are registered on the rising edge that leaves Update-DR. The bench counts them at the next falling edge, before any new input is driven. Read data returned by the access port is due only at the next access capture, so every scan compares its shifted-out word with the response that the bench's model last accepted, together with the OK or WAIT that the model predicts from its own outstanding-transaction state.

// File: rtl/jdp_pkg.sv
package jdp_pkg;
  typedef enum logic [3:0] {
    ST_TLR      = 4'h0,
    ST_IDLE     = 4'h1,
    ST_SEL_DR   = 4'h2,
    ST_CAP_DR   = 4'h3,
    ST_SHIFT_DR = 4'h4,
    ST_EXIT1_DR = 4'h5,
    ST_PAUSE_DR = 4'h6,
    ST_EXIT2_DR = 4'h7,
    ST_UPD_DR   = 4'h8,
    ST_SEL_IR   = 4'h9,
    ST_CAP_IR   = 4'hA,
    ST_SHIFT_IR = 4'hB,
    ST_EXIT1_IR = 4'hC,
    ST_PAUSE_IR = 4'hD,
    ST_EXIT2_IR = 4'hE,
    ST_UPD_IR   = 4'hF
  } tap_state_t;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] OP_IDENT   = 4'b1110;
  localparam logic [IR_W-1:0] OP_DPXS    = 4'b1010;
  localparam logic [IR_W-1:0] OP_APXS    = 4'b1011;
  localparam logic [IR_W-1:0] OP_ABORT   = 4'b1000;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  localparam int ACK_W = 3;
  localparam logic [ACK_W-1:0] ACK_WAIT = 3'b001;
  localparam logic [ACK_W-1:0] ACK_OK   = 3'b010;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_ACC, SEL_ABT} dr_sel_t;
endpackage

// File: rtl/jdp_tap_fsm.sv
module jdp_tap_fsm
  import jdp_pkg::*;
(
  input  logic       tck,
  input  logic       trst,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    case (state)
      ST_TLR:      nxt = tms ? ST_TLR      : ST_IDLE;
      ST_IDLE:     nxt = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nxt = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: nxt = tms ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   nxt = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   nxt = tms ? ST_TLR      : ST_CAP_IR;
      ST_CAP_IR:   nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nxt = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: nxt = tms ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   nxt = tms ? ST_SEL_DR   : ST_IDLE;
      default:     nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (trst) state <= ST_TLR;
    else      state <= nxt;
  end
endmodule

// File: rtl/jdp_ir.sv
module jdp_ir
  import jdp_pkg::*;
(
  input  logic            tck,
  input  logic            trst,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_out
);
  logic [IR_W-1:0] sr;

  always_ff @(posedge tck) begin
    if (trst) begin
      sr   <= IR_CAPTURE;
      ir_q <= OP_IDENT;
    end else begin
      case (state)
        ST_CAP_IR:   sr   <= IR_CAPTURE;
        ST_SHIFT_IR: sr   <= {tdi, sr[IR_W-1:1]};
        ST_UPD_IR:   ir_q <= sr;
        ST_TLR:      ir_q <= OP_IDENT;
        default: ;
      endcase
    end
  end

  assign ir_out = sr[0];
endmodule

// File: rtl/jdp_dr_chain.sv
module jdp_dr_chain
  import jdp_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              ACC_W    = 35,
  parameter int              ABT_W    = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h3BA0_0477
) (
  input  logic              tck,
  input  logic              trst,
  input  tap_state_t        state,
  input  logic [IR_W-1:0]   ir_q,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [ACK_W-1:0]  cap_ack,
  output logic [ACC_W-1:0]  sr
);
  localparam int ID_W = DATA_W;

  dr_sel_t          sel;
  logic [ACC_W-1:0] cap_val;
  logic [ACC_W-1:0] shifted;

  always_comb begin
    case (ir_q)
      OP_IDENT:          sel = SEL_ID;
      OP_DPXS, OP_APXS:  sel = SEL_ACC;
      OP_ABORT:          sel = SEL_ABT;
      default:           sel = SEL_BYP;
    endcase
  end

  always_comb begin
    case (sel)
      SEL_ID:  cap_val = ACC_W'(ID_VALUE);
      SEL_ACC: cap_val = ACC_W'({cap_data, cap_ack});
      default: cap_val = '0;
    endcase
  end

  // serial entry point depends on the selected register length
  always_comb begin
    shifted = sr >> 1;
    case (sel)
      SEL_ID:  shifted[ID_W-1]  = tdi;
      SEL_ACC: shifted[ACC_W-1] = tdi;
      SEL_ABT: shifted[ABT_W-1] = tdi;
      default: shifted[0]       = tdi;
    endcase
  end

  always_ff @(posedge tck) begin
    if (trst)                    sr <= '0;
    else if (state == ST_CAP_DR) sr <= cap_val;
    else if (state == ST_SHIFT_DR) sr <= shifted;
  end
endmodule

// File: rtl/jdp_dp_bank.sv
module jdp_dp_bank
  import jdp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int ACC_W  = 35
) (
  input  logic              tck,
  input  logic              trst,
  input  logic              cap_acc,
  input  logic              upd_dp,
  input  logic              upd_ap,
  input  logic              upd_abort,
  input  logic [ACC_W-1:0]  dr_in,
  input  logic              ap_rsp_valid,
  input  logic [DATA_W-1:0] ap_rsp_rdata,
  output logic [DATA_W-1:0] cap_data,
  output logic [ACK_W-1:0]  cap_ack,
  output logic              ap_req_valid,
  output logic              ap_req_write,
  output logic [ADDR_W-1:0] ap_req_addr,
  output logic [DATA_W-1:0] ap_req_wdata,
  output logic              ap_abort,
  output logic              pending
);
  localparam logic [ADDR_W-1:0] A_RSVD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(2);

  logic [DATA_W-1:0] ctrl_q, sel_q, rdbuf_q, last_q, rd_mux;
  logic              stall_q, pend_rd_q;
  logic [DATA_W-1:0] wdata;
  logic [ADDR_W-1:0] addr;
  logic              rd;

  assign wdata = dr_in[ACC_W-1 -: DATA_W];
  assign addr  = dr_in[ADDR_W:1];
  assign rd    = dr_in[0];

  assign cap_data = last_q;
  assign cap_ack  = pending ? ACK_WAIT : ACK_OK;

  always_comb begin
    case (addr)
      A_RSVD:  rd_mux = '0;
      A_CTRL:  rd_mux = ctrl_q;
      A_SEL:   rd_mux = sel_q;
      default: rd_mux = rdbuf_q;
    endcase
  end

  always_ff @(posedge tck) begin
    if (trst) begin
      ctrl_q       <= '0;
      sel_q        <= '0;
      rdbuf_q      <= '0;
      last_q       <= '0;
      stall_q      <= 1'b0;
      pend_rd_q    <= 1'b0;
      pending      <= 1'b0;
      ap_req_valid <= 1'b0;
      ap_req_write <= 1'b0;
      ap_req_addr  <= '0;
      ap_req_wdata <= '0;
      ap_abort     <= 1'b0;
    end else begin
      ap_req_valid <= 1'b0;
      ap_abort     <= 1'b0;
      if (cap_acc) stall_q <= pending;
      if (ap_rsp_valid && pending) begin
        pending <= 1'b0;
        if (pend_rd_q) begin
          rdbuf_q <= ap_rsp_rdata;
          last_q  <= ap_rsp_rdata;
        end
      end
      if (upd_dp && !stall_q) begin
        if (rd) last_q <= rd_mux;
        else if (addr == A_CTRL) ctrl_q <= wdata;
        else if (addr == A_SEL)  sel_q  <= wdata;
      end
      if (upd_ap && !stall_q) begin
        ap_req_valid <= 1'b1;
        ap_req_write <= !rd;
        ap_req_addr  <= addr;
        ap_req_wdata <= wdata;
        pending      <= 1'b1;
        pend_rd_q    <= rd;
      end
      if (upd_abort && dr_in[0]) begin
        ap_abort <= 1'b1;
        pending  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/jdp_port.sv
module jdp_port
  import jdp_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 2,
  parameter int                ABT_W    = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h3BA0_0477
) (
  input  logic              tck,
  input  logic              trst,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  output logic              ap_req_valid,
  output logic              ap_req_write,
  output logic [ADDR_W-1:0] ap_req_addr,
  output logic [DATA_W-1:0] ap_req_wdata,
  input  logic              ap_rsp_valid,
  input  logic [DATA_W-1:0] ap_rsp_rdata,
  output logic              ap_abort
);
  localparam int ACC_W = DATA_W + ADDR_W + 1;

  tap_state_t        tap_state;
  logic [IR_W-1:0]   ir_q;
  logic              ir_out;
  logic [ACC_W-1:0]  dr_sr;
  logic [DATA_W-1:0] cap_data;
  logic [ACK_W-1:0]  cap_ack;
  logic              ap_pending;
  logic              is_acc;

  assign is_acc = (ir_q == OP_DPXS) || (ir_q == OP_APXS);

  jdp_tap_fsm u_tap (
    .tck(tck), .trst(trst), .tms(tms), .state(tap_state)
  );

  jdp_ir u_ir (
    .tck(tck), .trst(trst), .state(tap_state), .tdi(tdi),
    .ir_q(ir_q), .ir_out(ir_out)
  );

  jdp_dr_chain #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .ABT_W(ABT_W), .ID_VALUE(ID_VALUE)
  ) u_dr (
    .tck(tck), .trst(trst), .state(tap_state), .ir_q(ir_q), .tdi(tdi),
    .cap_data(cap_data), .cap_ack(cap_ack), .sr(dr_sr)
  );

  jdp_dp_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACC_W(ACC_W)
  ) u_bank (
    .tck(tck), .trst(trst),
    .cap_acc(tap_state == ST_CAP_DR && is_acc),
    .upd_dp(tap_state == ST_UPD_DR && ir_q == OP_DPXS),
    .upd_ap(tap_state == ST_UPD_DR && ir_q == OP_APXS),
    .upd_abort(tap_state == ST_UPD_DR && ir_q == OP_ABORT),
    .dr_in(dr_sr),
    .ap_rsp_valid(ap_rsp_valid), .ap_rsp_rdata(ap_rsp_rdata),
    .cap_data(cap_data), .cap_ack(cap_ack),
    .ap_req_valid(ap_req_valid), .ap_req_write(ap_req_write),
    .ap_req_addr(ap_req_addr), .ap_req_wdata(ap_req_wdata),
    .ap_abort(ap_abort), .pending(ap_pending)
  );

  // serial output is launched on the falling edge
  always_ff @(negedge tck) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (tap_state == ST_SHIFT_IR) || (tap_state == ST_SHIFT_DR);
      if (tap_state == ST_SHIFT_IR)      tdo <= ir_out;
      else if (tap_state == ST_SHIFT_DR) tdo <= dr_sr[0];
      else                               tdo <= 1'b0;
    end
  end
endmodule

// File: rtl/jdp_port_chk.sv
module jdp_port_chk
  import jdp_pkg::*;
(
  input logic            tck,
  input logic            trst,
  input logic            tdo,
  input logic            tdo_en,
  input logic            ap_req_valid,
  input logic            ap_abort,
  input logic            ap_rsp_valid,
  input logic            ap_pending,
  input tap_state_t      tap_state,
  input logic [IR_W-1:0] ir_q
);
  a_r11_en_in_shift: assert property (@(posedge tck) disable iff (trst)
    tdo_en |-> (tap_state == ST_SHIFT_IR || tap_state == ST_SHIFT_DR));

  a_r11_quiet_low: assert property (@(posedge tck) disable iff (trst)
    !tdo_en |-> !tdo);

  a_r2_reset_opcode: assert property (@(posedge tck) disable iff (trst)
    (tap_state == ST_TLR) |=> (ir_q == OP_IDENT));

  a_r8_req_one_cycle: assert property (@(posedge tck) disable iff (trst)
    ap_req_valid |=> !ap_req_valid);

  a_r9_no_req_pending: assert property (@(posedge tck) disable iff (trst)
    (ap_pending && !ap_rsp_valid && !ap_abort) |=> !ap_req_valid);

  a_r10_abort_one_cycle: assert property (@(posedge tck) disable iff (trst)
    ap_abort |=> !ap_abort);

  a_r10_abort_clears: assert property (@(posedge tck) disable iff (trst)
    ap_abort |-> !ap_pending);
endmodule

bind jdp_port jdp_port_chk u_chk (
  .tck(tck), .trst(trst), .tdo(tdo), .tdo_en(tdo_en),
  .ap_req_valid(ap_req_valid), .ap_abort(ap_abort),
  .ap_rsp_valid(ap_rsp_valid), .ap_pending(ap_pending),
  .tap_state(tap_state), .ir_q(ir_q)
);

// File: tb/test_jdp_port.sv
`timescale 1ns/1ps
module test_jdp_port;
  logic        tck = 1'b0;
  logic        trst = 1'b1;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic        tdo, tdo_en;
  logic        ap_req_valid, ap_req_write, ap_abort;
  logic [1:0]  ap_req_addr;
  logic [31:0] ap_req_wdata;
  logic        ap_rsp_valid = 1'b0;
  logic [31:0] ap_rsp_rdata = '0;

  int n_chk = 0, n_err = 0;
  int req_cnt = 0, abort_cnt = 0, edge_bad = 0;
  logic last_en;
  logic        q_write;
  logic [1:0]  q_addr;
  logic [31:0] q_wdata;

  // bench model
  logic [31:0] m_ctrl = '0, m_sel = '0, m_rdbuf = '0, m_last = '0;
  logic        m_pending = 1'b0, m_pending_rd = 1'b0;

  jdp_port i_jdp_port (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .ap_req_valid(ap_req_valid), .ap_req_write(ap_req_write),
    .ap_req_addr(ap_req_addr), .ap_req_wdata(ap_req_wdata),
    .ap_rsp_valid(ap_rsp_valid), .ap_rsp_rdata(ap_rsp_rdata),
    .ap_abort(ap_abort)
  );

  always #10 tck = ~tck;

  always @(negedge tck) begin
    if (ap_req_valid) begin
      req_cnt++;
      q_write = ap_req_write; q_addr = ap_req_addr; q_wdata = ap_req_wdata;
    end
    if (ap_abort) abort_cnt++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #2;
    tms = m; tdi = d; o = tdo; last_en = tdo_en;
    @(posedge tck); #2;
    if (tdo !== o) edge_bad++;
  endtask

  task automatic shift_ir(input logic [3:0] op, output logic [3:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], o); cap[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic shift_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    int bad;
    bad = 0; dout = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], o); dout[i] = o;
      if (last_en !== 1'b1) bad++;
    end
    step(1, 0, o); step(0, 0, o);
    chk("R11 tdo_en high through shift", 64'(bad), 64'd0);
  endtask

  function automatic logic [31:0] dp_read(input logic [1:0] a);
    case (a)
      2'b01:   return m_ctrl;
      2'b10:   return m_sel;
      2'b11:   return m_rdbuf;
      default: return 32'h0;
    endcase
  endfunction

  task automatic acc_scan(input string tag, input logic is_ap, input logic [1:0] a,
                          input logic rd, input logic [31:0] wd);
    logic [63:0] dout;
    logic [2:0]  eack;
    int rq0;
    eack = m_pending ? 3'b001 : 3'b010;
    rq0 = req_cnt;
    shift_dr(35, {29'd0, wd, a, rd}, dout);
    chk({tag, " R6 data"}, 64'(dout[34:3]), 64'(m_last));
    chk({tag, " R6 ack"}, 64'(dout[2:0]), 64'(eack));
    @(negedge tck); #3;
    if (m_pending) begin
      chk({tag, " R9 dropped"}, 64'(req_cnt), 64'(rq0));
    end else if (is_ap) begin
      chk({tag, " R8 request count"}, 64'(req_cnt), 64'(rq0 + 1));
      chk({tag, " R8 R5 request fields"}, {29'd0, q_write, q_addr, q_wdata}, {29'd0, !rd, a, wd});
      m_pending = 1'b1; m_pending_rd = rd;
    end else begin
      chk({tag, " R7 no ap request"}, 64'(req_cnt), 64'(rq0));
      if (rd) m_last = dp_read(a);
      else if (a == 2'b01) m_ctrl = wd;
      else if (a == 2'b10) m_sel = wd;
    end
  endtask

  task automatic ap_respond(input logic [31:0] d);
    @(negedge tck); #2;
    ap_rsp_valid = 1'b1; ap_rsp_rdata = d;
    @(negedge tck); #2;
    ap_rsp_valid = 1'b0;
    if (m_pending) begin
      m_pending = 1'b0;
      if (m_pending_rd) begin m_rdbuf = d; m_last = d; end
    end
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic o;
    logic [3:0] cap;
    logic [63:0] dout;
    int a0;
    void'($urandom(32'h0000_5EED));

    repeat (3) @(posedge tck);
    @(negedge tck); #2; trst = 1'b0;
    @(negedge tck); #3;
    chk("R11 reset tdo_en", 64'(tdo_en), 64'd0);
    chk("R11 reset tdo", 64'(tdo), 64'd0);
    chk("R8 reset request", 64'(ap_req_valid), 64'd0);
    chk("R10 reset abort", 64'(ap_abort), 64'd0);
    step(0, 0, o);

    // R2 R4: identification selected after reset
    shift_dr(32, 64'd0, dout);
    chk("R4 ident value", dout[31:0], 64'h3BA0_0477);
    chk("R4 version field", 64'(dout[31:28]), 64'h3);
    chk("R4 part field", 64'(dout[27:12]), 64'hBA00);
    chk("R4 fixed bit", 64'(dout[0]), 64'd1);
    shift_dr(40, 64'hA5, dout);
    chk("R3 ident length 32", 64'(dout[39:32]), 64'hA5);
    @(negedge tck); #3;
    chk("R11 idle tdo_en", 64'(tdo_en), 64'd0);

    shift_ir(4'b1111, cap);
    chk("R2 ir capture", 64'(cap), 64'b0001);
    shift_dr(8, 64'hA5, dout);
    chk("R4 R3 bypass", dout[7:0], {56'd0, 8'h4A});

    // R3 fallback for every unlisted opcode
    for (int op = 0; op < 16; op++) begin
      if (op != 15 && op != 14 && op != 10 && op != 11 && op != 8) begin
        shift_ir(4'(op), cap);
        shift_dr(8, 64'h3C, dout);
        chk($sformatf("R3 opcode %b falls back to bypass", 4'(op)), dout[7:0], 64'h78);
      end
    end

    // R1: five TMS-high edges from inside Shift-DR
    shift_ir(4'b1111, cap);
    step(1, 0, o); step(0, 0, o); step(0, 0, o); step(0, 1, o);
    repeat (5) step(1, 0, o);
    step(0, 0, o);
    shift_dr(32, 64'd0, dout);
    chk("R1 five tms high resets to ident", dout[31:0], 64'h3BA0_0477);

    // R7 debug-port bank
    shift_ir(4'b1010, cap);
    acc_scan("R7 ctrl write", 0, 2'b01, 0, 32'h1234_5678);
    acc_scan("R7 select write", 0, 2'b10, 0, 32'hCAFE_F00D);
    acc_scan("R7 reserved write", 0, 2'b00, 0, 32'hFFFF_FFFF);
    acc_scan("R7 rdbuff write", 0, 2'b11, 0, 32'h0000_DEAD);
    acc_scan("R7 reserved read", 0, 2'b00, 1, 32'h0);
    acc_scan("R7 ctrl read", 0, 2'b01, 1, 32'h0);
    acc_scan("R7 select read", 0, 2'b10, 1, 32'h0);
    acc_scan("R7 rdbuff read", 0, 2'b11, 1, 32'h0);
    acc_scan("R7 read after", 0, 2'b00, 1, 32'h0);

    // R8 access port
    shift_ir(4'b1011, cap);
    acc_scan("R8 ap write", 1, 2'b01, 0, 32'h0BAD_F00D);
    ap_respond(32'h1111_1111);
    acc_scan("R8 ap read", 1, 2'b11, 1, 32'h0);
    ap_respond(32'h8765_4321);
    acc_scan("R8 ap read result", 1, 2'b00, 1, 32'h0);
    ap_respond(32'h0F0F_0F0F);

    // R9 WAIT on both access kinds
    acc_scan("R9 ap issue", 1, 2'b10, 1, 32'h0);
    acc_scan("R9 ap wait", 1, 2'b01, 0, 32'h5555_AAAA);
    shift_ir(4'b1010, cap);
    acc_scan("R9 dp wait", 0, 2'b01, 0, 32'h7777_7777);
    ap_respond(32'h2468_ACE0);
    acc_scan("R9 dp ctrl unchanged", 0, 2'b01, 1, 32'h0);
    acc_scan("R9 dp ok again", 0, 2'b11, 1, 32'h0);

    // R10 abort
    shift_ir(4'b1011, cap);
    acc_scan("R10 ap issue", 1, 2'b00, 1, 32'h0);
    shift_ir(4'b1000, cap);
    a0 = abort_cnt;
    shift_dr(32, 64'h0, dout);
    @(negedge tck); #3;
    chk("R10 abort capture zero", dout[31:0], 64'd0);
    chk("R10 bit0 clear no pulse", 64'(abort_cnt), 64'(a0));
    shift_ir(4'b1011, cap);
    acc_scan("R10 still pending", 1, 2'b00, 0, 32'h0);
    shift_ir(4'b1000, cap);
    shift_dr(32, 64'h1, dout);
    @(negedge tck); #3;
    chk("R10 abort pulse", 64'(abort_cnt), 64'(a0 + 1));
    m_pending = 1'b0;
    shift_ir(4'b1010, cap);
    acc_scan("R10 ok after abort", 0, 2'b01, 1, 32'h0);

    // random mix R5 R6 R7 R8 R9
    for (int k = 0; k < 70; k++) begin
      logic is_ap, rd;
      logic [1:0] a;
      logic [31:0] wd;
      is_ap = 1'($urandom_range(0, 1));
      rd = 1'($urandom_range(0, 1));
      a = 2'($urandom_range(0, 3));
      wd = $urandom;
      shift_ir(is_ap ? 4'b1011 : 4'b1010, cap);
      acc_scan("R5 random", is_ap, a, rd, wd);
      if ($urandom_range(0, 3) != 0) ap_respond($urandom);
    end

    chk("R11 tdo stable across rising edges", 64'(edge_bad), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule